// File: doc/BRIEF.md
# Row-Buffered DRAM Array with Request Controller

This block models a small dynamic memory of 16 supercells of 8 bits each, arranged as 4 rows by 4 columns, together with the controller that sits in front of it. The array is reached only through a narrow shared address bus. A row strobe with the row index on that bus copies the whole row into an internal row buffer. A column strobe with the column index then selects one supercell of the buffer, either to read it out or to overwrite it. The controller takes one full (row, column) read or write request at a time from a valid/ready handshake. It sends the row index first and the column index second. When the requested row is already open it skips the row phase.

Writes land in the row buffer. The array row is brought up to date when the buffer is written back, which happens before a different row is opened or when a refresh precharges the buffer. A free-running interval counter raises a refresh request. Refresh takes priority over a waiting request. It writes back any open row and then reads and rewrites every row in turn, leaving the buffer closed.

Top module: `dram_rowbuf_top`

## Requirements
- R1: Directly after reset, reqReady is 1, rspValid is 0, rspRdata is 0, every supercell reads as 0, and the row buffer is closed.
- R2: A read of (row, column) returns the last value written to that supercell on rspRdata, in the cycle where rspValid is 1.
- R3: A write changes only the addressed supercell. Every other supercell keeps its value.
- R4: When the requested row is the open row, rspValid is 1 in the second cycle after the accepting cycle (column phase only).
- R5: When the buffer is closed, rspValid is 1 in the third cycle after the accepting cycle (row phase, then column phase).
- R6: When another row is open, rspValid is 1 in the fourth cycle after the accepting cycle. That row is written back first, so its pending writes are kept.
- R7: Only one request is in flight. reqReady is 0 from the cycle after acceptance until the response, and rspValid is high for exactly one cycle per request.
- R8: While idle, a refresh starts every REFRESH_CYCLES cycles and holds reqReady at 0 for 2 + 2*ROWS cycles.
- R9: A refresh keeps all data, including writes still held only in the open row buffer, and closes the buffer, so the next access takes the closed-buffer latency of R5.
- R10: A request raised while a refresh is under way is not accepted until the refresh ends. It is then served with the latency of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | 2 | Row index of the supercell |
| reqCol | input | 2 | Column index of the supercell |
| reqWdata | input | 8 | Data to write |
| rspValid | output | 1 | One-cycle pulse marking completion |
| rspRdata | output | 8 | Read data, valid with rspValid |

## Verification
The hardest situation to reach is a refresh that lands on a row buffer holding writes that exist nowhere else, followed at once by a request that must wait behind the refresh. The stimulus writes into an open row and then idles until reqReady drops. It raises a read at the first stalled cycle and confirms both the stall length and that the dirty data survived. A reference model in the bench tracks which row should be open and whether a refresh has closed it, so that every request in the vector walk gets an exact expected latency covering hit, closed and conflicting rows.

// File: rtl/dram_rowbuf_pkg.sv
package dram_rowbuf_pkg;

  // Strobes from the controller to the array datapath
  typedef struct packed {
    logic ras;    // load row addrBus into the row buffer
    logic casRd;  // read supercell addrBus from the row buffer
    logic casWr;  // write supercell addrBus in the row buffer
    logic wback;  // restore the row buffer into its array row
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_RAS,
    ST_CAS,
    ST_REF_PRE,
    ST_REF_ACT,
    ST_REF_RW
  } state_t;

endpackage

// File: rtl/dram_rowbuf_array.sv
module dram_rowbuf_array
  import dram_rowbuf_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [AW-1:0]    addrBus,
  input  logic [WIDTH-1:0] wdataBus,
  output logic [WIDTH-1:0] rdata
);

  localparam int ROW_W = COLS * WIDTH;
  localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;

  logic [ROW_W-1:0] cells [ROWS];
  logic [ROW_W-1:0] rowBuf;
  logic [RW-1:0]    rowLatch;
  logic [WIDTH-1:0] bufSlice [COLS];
  logic [RW-1:0]    rowSel;
  logic [CW-1:0]    colSel;

  assign rowSel = addrBus[RW-1:0];
  assign colSel = addrBus[CW-1:0];

  // Column view of the row buffer
  for (genvar c = 0; c < COLS; c++) begin : g_slice
    assign bufSlice[c] = rowBuf[c*WIDTH +: WIDTH];
  end

  // Array rows: each is rewritten only from the row buffer
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[r] <= '0;
      end else if (strb.wback && rowLatch == RW'(r)) begin
        cells[r] <= rowBuf;
      end
    end
  end

  // Row buffer and its row latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowBuf   <= '0;
      rowLatch <= '0;
    end else if (strb.ras) begin
      rowBuf   <= cells[rowSel];
      rowLatch <= rowSel;
    end else if (strb.casWr) begin
      rowBuf[colSel*WIDTH +: WIDTH] <= wdataBus;
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (strb.casRd) begin
      rdata <= bufSlice[colSel];
    end
  end

endmodule

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl
  import dram_rowbuf_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int WIDTH          = 8,
  parameter int AW             = 2,
  parameter int REFRESH_CYCLES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqRow,
  input  logic [AW-1:0]    reqCol,
  input  logic [WIDTH-1:0] reqWdata,
  output logic             rspValid,
  output strobe_t          strb,
  output logic [AW-1:0]    addrBus,
  output logic [WIDTH-1:0] wdataBus
);

  localparam int CNT_W = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;

  state_t           state;
  logic             opWrite;
  logic [AW-1:0]    opRow;
  logic [AW-1:0]    opCol;
  logic [WIDTH-1:0] opData;
  logic             bufOpen;
  logic [AW-1:0]    openRow;
  logic [AW-1:0]    refRow;
  logic             refPending;
  logic [CNT_W-1:0] refCnt;
  logic             refStart;

  assign reqReady = (state == ST_IDLE) && !refPending;
  assign refStart = (state == ST_IDLE) && refPending;
  assign wdataBus = opData;

  // Refresh interval timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (refStart) refPending <= 1'b0;
      if (refCnt == CNT_W'(REFRESH_CYCLES - 1)) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      opWrite  <= 1'b0;
      opRow    <= '0;
      opCol    <= '0;
      opData   <= '0;
      bufOpen  <= 1'b0;
      openRow  <= '0;
      refRow   <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (refPending) begin
            state <= ST_REF_PRE;
          end else if (reqValid) begin
            opWrite <= reqWrite;
            opRow   <= reqRow;
            opCol   <= reqCol;
            opData  <= reqWdata;
            if (bufOpen && openRow == reqRow) state <= ST_CAS;
            else if (bufOpen)                 state <= ST_WBACK;
            else                              state <= ST_RAS;
          end
        end
        ST_WBACK: begin
          bufOpen <= 1'b0;
          state   <= ST_RAS;
        end
        ST_RAS: begin
          bufOpen <= 1'b1;
          openRow <= opRow;
          state   <= ST_CAS;
        end
        ST_CAS: begin
          rspValid <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_REF_PRE: begin
          bufOpen <= 1'b0;
          refRow  <= '0;
          state   <= ST_REF_ACT;
        end
        ST_REF_ACT: begin
          state <= ST_REF_RW;
        end
        ST_REF_RW: begin
          if (refRow == AW'(ROWS - 1)) begin
            state <= ST_IDLE;
          end else begin
            refRow <= refRow + 1'b1;
            state  <= ST_REF_ACT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe and multiplexed address generation
  always_comb begin
    strb    = '0;
    addrBus = '0;
    unique case (state)
      ST_WBACK:   strb.wback = 1'b1;
      ST_RAS: begin
        strb.ras = 1'b1;
        addrBus  = opRow;
      end
      ST_CAS: begin
        strb.casRd = !opWrite;
        strb.casWr = opWrite;
        addrBus    = opCol;
      end
      ST_REF_PRE: strb.wback = bufOpen;
      ST_REF_ACT: begin
        strb.ras = 1'b1;
        addrBus  = refRow;
      end
      ST_REF_RW:  strb.wback = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_rowbuf_top.sv
module dram_rowbuf_top
  import dram_rowbuf_pkg::*;
#(
  parameter int ROWS           = 4,
  parameter int COLS           = 4,
  parameter int WIDTH          = 8,
  parameter int REFRESH_CYCLES = 512,
  localparam int RW            = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW            = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW            = (RW > CW) ? RW : CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [AW-1:0]    reqRow,
  input  logic [AW-1:0]    reqCol,
  input  logic [WIDTH-1:0] reqWdata,
  output logic             rspValid,
  output logic [WIDTH-1:0] rspRdata
);

  strobe_t          strb;
  logic [AW-1:0]    addrBus;
  logic [WIDTH-1:0] wdataBus;

  dram_rowbuf_ctrl #(
    .ROWS(ROWS), .WIDTH(WIDTH), .AW(AW), .REFRESH_CYCLES(REFRESH_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .rspValid(rspValid),
    .strb(strb), .addrBus(addrBus), .wdataBus(wdataBus)
  );

  dram_rowbuf_array #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .AW(AW)
  ) array_i (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .addrBus(addrBus), .wdataBus(wdataBus),
    .rdata(rspRdata)
  );

endmodule

// File: rtl/dram_rowbuf_chk.sv
module dram_rowbuf_chk
  import dram_rowbuf_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic [WIDTH-1:0] rspRdata,
  input strobe_t          strb
);

  // R7: response is a single-cycle pulse
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R7: no second acceptance while a request is in flight
  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R6: at most one array strobe per cycle
  a_r6_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.ras, strb.casRd, strb.casWr, strb.wback}));

  // R2: read data moves only together with a response
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rspRdata) |-> rspValid);

  // R10: row phases never overlap an accepting cycle
  a_r10_ready_low_on_ras: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ras |-> !reqReady);

endmodule

bind dram_rowbuf_top dram_rowbuf_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspRdata(rspRdata), .strb(strb)
);

// File: tb/dram_rowbuf_top_tb_top.sv
`timescale 1ns/1ps
module dram_rowbuf_top_tb_top;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int WIDTH = 8;
  localparam int REF   = 48;
  localparam int NVEC  = 16;
  localparam int STALL = 2 + 2 * ROWS;

  // vector: {write, row[1:0], col[1:0], data[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 2'd0, 8'h11}, {1'b0, 2'd0, 2'd0, 8'h00},
    {1'b1, 2'd0, 2'd3, 8'h22}, {1'b0, 2'd0, 2'd3, 8'h00},
    {1'b0, 2'd2, 2'd1, 8'h00}, {1'b1, 2'd2, 2'd1, 8'h33},
    {1'b0, 2'd0, 2'd0, 8'h00}, {1'b0, 2'd2, 2'd1, 8'h00},
    {1'b1, 2'd3, 2'd3, 8'hFF}, {1'b0, 2'd3, 2'd0, 8'h00},
    {1'b1, 2'd1, 2'd2, 8'h44}, {1'b0, 2'd3, 2'd3, 8'h00},
    {1'b0, 2'd1, 2'd2, 8'h00}, {1'b0, 2'd0, 2'd3, 8'h00},
    {1'b1, 2'd0, 2'd3, 8'h55}, {1'b0, 2'd0, 2'd3, 8'h00}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic             reqWrite = 1'b0;
  logic [1:0]       reqRow = '0;
  logic [1:0]       reqCol = '0;
  logic [WIDTH-1:0] reqWdata = '0;
  logic             rspValid;
  logic [WIDTH-1:0] rspRdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit inFlight = 1'b0;
  bit modelOpen = 1'b0;
  int modelRow = 0;
  logic [WIDTH-1:0] shadow [ROWS][COLS];

  always #2 clk = ~clk;

  dram_rowbuf_top #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .REFRESH_CYCLES(REF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // A stall outside a request can only be a refresh: it closes the row
  always @(negedge clk) begin
    if (rst_n && !inFlight && !reqReady) modelOpen = 1'b0;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReq(input bit wr, input int row, input int col,
                       input logic [WIDTH-1:0] data, output int waited);
    int expLat;
    int lat;
    string tag;
    waited = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr;
    reqRow = 2'(row); reqCol = 2'(col); reqWdata = data;
    while (!reqReady) begin
      waited++;
      @(negedge clk);
    end
    @(posedge clk);
    inFlight = 1'b1;
    if (modelOpen && modelRow == row) begin expLat = 2; tag = "R4"; end
    else if (modelOpen)               begin expLat = 4; tag = "R6"; end
    else                              begin expLat = 3; tag = "R5"; end
    modelOpen = 1'b1;
    modelRow  = row;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        reqValid = 1'b0;
        check(reqReady == 1'b0, "R7", "ready while in flight", int'(reqReady), 0);
      end
    end while (!rspValid && lat < 20);
    check(lat == expLat, tag, "response latency", lat, expLat);
    if (!wr) begin
      check(rspRdata == shadow[row][col], (lat == 4) ? "R6" : "R2",
            "read data", int'(rspRdata), int'(shadow[row][col]));
    end else begin
      shadow[row][col] = data;
    end
    inFlight = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0, "R7", "response pulse width", int'(rspValid), 0);
  endtask

  task automatic waitFall();
    int n = 0;
    @(negedge clk);
    while (!reqReady && n < 400) begin @(negedge clk); n++; end
    while (reqReady && n < 400) begin @(negedge clk); n++; end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R7", "watchdog cycles", 100000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w;
    int t0;
    int len;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) shadow[r][c] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "ready after reset", int'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "no response after reset", int'(rspValid), 0);
    check(rspRdata == '0, "R1", "read data after reset", int'(rspRdata), 0);

    // R2 R3 R4 R5 R6: vector walk against the reference model
    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i][12], int'(VEC[i][11:10]), int'(VEC[i][9:8]), VEC[i][7:0], w);
    end

    // R3: untouched cells still read zero
    doReq(1'b0, 1, 0, 8'h00, w);
    doReq(1'b0, 2, 3, 8'h00, w);

    // R8: refresh stall length and period while idle
    waitFall();
    t0 = cyc;
    len = 0;
    while (!reqReady && len < 100) begin @(negedge clk); len++; end
    check(len == STALL, "R8", "refresh stall length", len, STALL);
    while (reqReady && (cyc - t0) < 400) @(negedge clk);
    check((cyc - t0) == REF, "R8", "refresh period", cyc - t0, REF);

    // R9: dirty open row survives refresh, buffer closed afterwards
    doReq(1'b1, 1, 1, 8'hA5, w);
    waitFall();
    while (!reqReady) @(negedge clk);
    doReq(1'b0, 1, 1, 8'h00, w);
    check(shadow[1][1] == 8'hA5, "R9", "model holds dirty data",
          int'(shadow[1][1]), 'hA5);

    // R10: request raised on the first stalled cycle waits out the refresh
    doReq(1'b1, 3, 1, 8'h6C, w);
    waitFall();
    reqValid = 1'b1; reqWrite = 1'b0; reqRow = 2'd3; reqCol = 2'd1;
    w = 0;
    while (!reqReady) begin w++; @(negedge clk); end
    check(w == STALL, "R10", "cycles held off by refresh", w, STALL);
    reqValid = 1'b0;
    doReq(1'b0, 3, 1, 8'h00, w);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule